// File: doc/BRIEF.md
# Chassis Slot-Management Register File

This block is the register file of a supervisor board's midplane controller. A CPU bus (address, write strobe, read strobe, 32-bit write data) reaches a small set of registers. One selector register picks a line-card slot and a sub-function. A shared status register then answers according to that choice: presence, power-good, power-converter health, or the data-out bit of the selected slot's serial EEPROM. When the selector is written with the power function, the selected slot's powered-on flag is also set as a side effect, and the flag stays set until reset.

The block drives the bit-banged serial lines (data-in, clock, chip selects) of the backplane, supervisor and slot EEPROMs. It returns their data-out bits through read registers, and it supplies a fixed slot-identification word and some constant registers. A per-slot network-interrupt aggregator holds one pending bit per slot and drives a single interrupt line. The EEPROM devices themselves are not part of the block: their data-out bits and the slot presence flags are plain inputs.

The bus is handled by a two-state machine. In `BUS_IDLE` an access is accepted. If write and read are both high, the write wins and no read takes place. The transition `IDLE_TO_RESP` happens on an accepted read, and `BUS_RESP` presents the read data with a valid flag for one cycle. The transition `RESP_TO_IDLE` always follows. Any access presented during `BUS_RESP` is dropped.

Top module: `slot_mgmt_regs`

## Requirements
- R1: After reset all powered-on flags are clear, the interrupt line and every EEPROM chip-select, clock and data-in output are low, and the selector holds 0, so a status read reports an absent slot (value 1).
- R2: A selector write (offset 0x44) with function code 2 in bits 11:8 sets the powered-on flag of the slot in bits 15:12 (slot numbers start at 1). The flag stays set when later selector writes use other functions, and writes with other functions set no flag.
- R3: A selector write whose slot field is 0 or above NUM_SLOTS changes no powered-on flag. With such a slot selected, function 0 and function 1 read 1 and function 5 reads 0.
- R4: Status read (offset 0x4C) with function 0: an absent slot returns 1. A present slot returns 2 if its powered-on flag is set or it is slot SUP_SLOT, and 0 otherwise.
- R5: Status read with function 1 returns 1 for an absent slot and 0 for a present slot.
- R6: Status read with function 2 returns 0x08. Any function other than 0, 1, 2 and 5 returns 0.
- R7: The slot EEPROM control register (offset 0x48) drives the data-in output from bit 0 and the clock output from bit 1. Bit 3 is a chip select that reaches only the selected valid slot's one-hot chip-select output. With function 5 selected, a status read returns that slot's data-out in bit 0 while its chip select is active, and 0 otherwise.
- R8: A read of offset 0x04 returns (SUP_SLOT << 8) | 0x80.
- R9: A read of offset 0x3C returns, in bit 0, the OR of data-out over backplane EEPROMs whose chip select is active. If any supervisor EEPROM with an active chip select has data-out high, bits 15:0 read 0xFFFF instead.
- R10: The backplane EEPROM control register (offset 0x20) drives data-in from bit 0, clock from bit 1 and chip select i from bit 3+i. The supervisor EEPROM control register (offset 0x24) drives EEPROM 0 from clock bit 1, data-in bit 2 and chip-select bit 3, and EEPROM 1 from chip-select bit 8, data-in bit 9 and clock bit 10.
- R11: Each slot has a network-interrupt pending bit. A set pulse sets it and a clear pulse clears it, with set winning when both arrive together. The interrupt output is high whenever any pending bit is set.
- R12: Offsets 0x0C, 0x14, 0x1C, 0x50 and 0x74 read 0. Offset 0x18 reads 0x8000. Every other offset, including the write-only control and selector registers, reads 0xFFFFFFFF.
- R13: Read data and a one-cycle valid flag appear in the cycle after an accepted read. Any access presented in that response cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response valid |
| slot_present | input | NUM_SLOTS | Presence flag per slot (bit i = slot i+1) |
| slot_ee_dout | input | NUM_SLOTS | Slot EEPROM data-out per slot |
| slot_ee_di | output | 1 | Slot EEPROM serial data-in |
| slot_ee_clk | output | 1 | Slot EEPROM serial clock |
| slot_ee_cs | output | NUM_SLOTS | Slot EEPROM chip select, one-hot on selected slot |
| bp_ee_dout | input | NUM_BP_EE | Backplane EEPROM data-out bits |
| bp_ee_di | output | 1 | Backplane EEPROM serial data-in |
| bp_ee_clk | output | 1 | Backplane EEPROM serial clock |
| bp_ee_cs | output | NUM_BP_EE | Backplane EEPROM chip selects |
| sup_ee_dout | input | 2 | Supervisor EEPROM data-out bits |
| sup_ee_di | output | 2 | Supervisor EEPROM data-in |
| sup_ee_clk | output | 2 | Supervisor EEPROM clocks |
| sup_ee_cs | output | 2 | Supervisor EEPROM chip selects |
| net_irq_set | input | NUM_SLOTS | Per-slot interrupt set pulse |
| net_irq_clr | input | NUM_SLOTS | Per-slot interrupt clear pulse |
| net_irq | output | 1 | Aggregated network interrupt |

## Verification
The status register is read with each function against a mix of present, absent, supervisor, powered and out-of-range slots. This separates the function decode from the slot decode and shows that an out-of-range slot never aliases a real one (slot 10 must not touch slot 9 or slot 1). Powered-on stickiness is shown by writing the power function and then reading through function 0 under a different selector value. The EEPROM read-back register is driven with data-out bits on both selected and unselected chips, so masking is told apart from a plain OR. A write issued in the read response cycle must leave both the selector and the flags untouched.

// File: rtl/slot_mgmt_pkg.sv
package slot_mgmt_pkg;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    localparam int OFS_SLOT_ID  = 'h04;
    localparam int OFS_ZERO_A   = 'h0C;
    localparam int OFS_ZERO_B   = 'h14;
    localparam int OFS_CONST    = 'h18;
    localparam int OFS_ZERO_C   = 'h1C;
    localparam int OFS_BP_CTL   = 'h20;
    localparam int OFS_SUP_CTL  = 'h24;
    localparam int OFS_EE_RD    = 'h3C;
    localparam int OFS_SELECT   = 'h44;
    localparam int OFS_SLOT_CTL = 'h48;
    localparam int OFS_STATUS   = 'h4C;
    localparam int OFS_ZERO_D   = 'h50;
    localparam int OFS_ZERO_E   = 'h74;

    localparam logic [3:0] FN_PRESENCE = 4'd0;
    localparam logic [3:0] FN_ABSENT   = 4'd1;
    localparam logic [3:0] FN_POWER    = 4'd2;
    localparam logic [3:0] FN_EEPROM   = 4'd5;

endpackage

// File: rtl/slot_select.sv
module slot_select
    import slot_mgmt_pkg::*;
#(
    parameter int NUM_SLOTS = 9,
    localparam int SLOT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_sel,
    input  logic                 wr_ctl,
    input  logic [31:0]          wdata,
    output logic [SLOT_W-1:0]    sel_slot,
    output logic [3:0]           sel_func,
    output logic [NUM_SLOTS-1:0] sel_onehot,
    output logic [NUM_SLOTS-1:0] pwr_flags,
    output logic                 ee_di,
    output logic                 ee_clk,
    output logic                 ee_cs_raw,
    output logic [NUM_SLOTS-1:0] ee_cs
);
    logic [SLOT_W-1:0] w_slot;
    logic [3:0]        w_func;

    assign w_slot = wdata[15:12];
    assign w_func = wdata[11:8];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_slot  <= '0;
            sel_func  <= '0;
            ee_di     <= 1'b0;
            ee_clk    <= 1'b0;
            ee_cs_raw <= 1'b0;
        end else begin
            if (wr_sel) begin
                sel_slot <= w_slot;
                sel_func <= w_func;
            end
            if (wr_ctl) begin
                ee_di     <= wdata[0];
                ee_clk    <= wdata[1];
                ee_cs_raw <= wdata[3];
            end
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign sel_onehot[g] = (sel_slot == SLOT_W'(g + 1));
        assign ee_cs[g]      = ee_cs_raw && sel_onehot[g];

        always_ff @(posedge clk) begin
            if (!rst_n)
                pwr_flags[g] <= 1'b0;
            else if (wr_sel && w_func == FN_POWER && w_slot == SLOT_W'(g + 1))
                pwr_flags[g] <= 1'b1;
        end
    end

    AST_PWR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwr_flags & $past(pwr_flags)) == $past(pwr_flags))); // R2
    AST_PWR_ONLY_FN2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_flags != $past(pwr_flags)) |-> ($past(wr_sel) && $past(wdata[11:8]) == FN_POWER)); // R3
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ee_cs)); // R7

endmodule

// File: rtl/eeprom_ctl.sv
module eeprom_ctl
    import slot_mgmt_pkg::*;
#(
    parameter int NUM_BP_EE = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_bp,
    input  logic                 wr_sup,
    input  logic [31:0]          wdata,
    input  logic [NUM_BP_EE-1:0] bp_dout,
    input  logic [1:0]           sup_dout,
    output logic                 bp_di,
    output logic                 bp_clk,
    output logic [NUM_BP_EE-1:0] bp_cs,
    output logic [1:0]           sup_di,
    output logic [1:0]           sup_clk,
    output logic [1:0]           sup_cs,
    output logic [31:0]          rd_word
);
    localparam int CS_LSB = 3;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_di   <= 1'b0;
            bp_clk  <= 1'b0;
            bp_cs   <= '0;
            sup_di  <= '0;
            sup_clk <= '0;
            sup_cs  <= '0;
        end else begin
            if (wr_bp) begin
                bp_di  <= wdata[0];
                bp_clk <= wdata[1];
                bp_cs  <= wdata[CS_LSB +: NUM_BP_EE];
            end
            if (wr_sup) begin
                sup_clk <= {wdata[10], wdata[1]};
                sup_di  <= {wdata[9],  wdata[2]};
                sup_cs  <= {wdata[8],  wdata[3]};
            end
        end
    end

    logic bp_any;
    logic sup_any;

    assign bp_any  = |(bp_cs & bp_dout);
    assign sup_any = |(sup_cs & sup_dout);

    always_comb begin
        rd_word = {31'd0, bp_any};
        if (sup_any)
            rd_word[15:0] = 16'hFFFF;
    end

    AST_SUP_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sup_cs & sup_dout)) |-> (rd_word[15:0] == 16'hFFFF)); // R9

endmodule

// File: rtl/net_irq_agg.sv
module net_irq_agg #(
    parameter int NUM_SLOTS = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] set_i,
    input  logic [NUM_SLOTS-1:0] clr_i,
    output logic                 irq_o
);
    logic [NUM_SLOTS-1:0] pend_q;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_pend
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q[g] <= 1'b0;
            else if (set_i[g])
                pend_q[g] <= 1'b1;
            else if (clr_i[g])
                pend_q[g] <= 1'b0;
        end
    end

    assign irq_o = |pend_q;

    AST_IRQ_ON_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> irq_o); // R11

endmodule

// File: rtl/slot_mgmt_regs.sv
module slot_mgmt_regs
    import slot_mgmt_pkg::*;
#(
    parameter int NUM_SLOTS = 9,
    parameter int SUP_SLOT  = 1,
    parameter int NUM_BP_EE = 9,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 bus_rvalid,
    input  logic [NUM_SLOTS-1:0] slot_present,
    input  logic [NUM_SLOTS-1:0] slot_ee_dout,
    output logic                 slot_ee_di,
    output logic                 slot_ee_clk,
    output logic [NUM_SLOTS-1:0] slot_ee_cs,
    input  logic [NUM_BP_EE-1:0] bp_ee_dout,
    output logic                 bp_ee_di,
    output logic                 bp_ee_clk,
    output logic [NUM_BP_EE-1:0] bp_ee_cs,
    input  logic [1:0]           sup_ee_dout,
    output logic [1:0]           sup_ee_di,
    output logic [1:0]           sup_ee_clk,
    output logic [1:0]           sup_ee_cs,
    input  logic [NUM_SLOTS-1:0] net_irq_set,
    input  logic [NUM_SLOTS-1:0] net_irq_clr,
    output logic                 net_irq
);
    localparam int SLOT_W = 4;
    localparam logic [31:0] SLOT_ID_WORD = (32'(SUP_SLOT) << 8) | 32'h80;

    bus_state_e state_q, state_d;
    logic       acc_wr, acc_rd;

    assign acc_wr = (state_q == BUS_IDLE) && bus_wr;
    assign acc_rd = (state_q == BUS_IDLE) && bus_rd && !bus_wr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (acc_rd) state_d = BUS_RESP;   // IDLE_TO_RESP
            BUS_RESP: state_d = BUS_IDLE;               // RESP_TO_IDLE
            default:  state_d = BUS_IDLE;
        endcase
    end

    logic wr_sel, wr_sctl, wr_bp, wr_sup;
    assign wr_sel  = acc_wr && bus_addr == ADDR_W'(OFS_SELECT);
    assign wr_sctl = acc_wr && bus_addr == ADDR_W'(OFS_SLOT_CTL);
    assign wr_bp   = acc_wr && bus_addr == ADDR_W'(OFS_BP_CTL);
    assign wr_sup  = acc_wr && bus_addr == ADDR_W'(OFS_SUP_CTL);

    logic [SLOT_W-1:0]    sel_slot;
    logic [3:0]           sel_func;
    logic [NUM_SLOTS-1:0] sel_onehot;
    logic [NUM_SLOTS-1:0] pwr_flags;
    logic                 slot_cs_raw;
    logic [31:0]          ee_word;

    slot_select #(.NUM_SLOTS(NUM_SLOTS)) i_slot_select (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_sel     (wr_sel),
        .wr_ctl     (wr_sctl),
        .wdata      (bus_wdata),
        .sel_slot   (sel_slot),
        .sel_func   (sel_func),
        .sel_onehot (sel_onehot),
        .pwr_flags  (pwr_flags),
        .ee_di      (slot_ee_di),
        .ee_clk     (slot_ee_clk),
        .ee_cs_raw  (slot_cs_raw),
        .ee_cs      (slot_ee_cs)
    );

    eeprom_ctl #(.NUM_BP_EE(NUM_BP_EE)) i_eeprom_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_bp    (wr_bp),
        .wr_sup   (wr_sup),
        .wdata    (bus_wdata),
        .bp_dout  (bp_ee_dout),
        .sup_dout (sup_ee_dout),
        .bp_di    (bp_ee_di),
        .bp_clk   (bp_ee_clk),
        .bp_cs    (bp_ee_cs),
        .sup_di   (sup_ee_di),
        .sup_clk  (sup_ee_clk),
        .sup_cs   (sup_ee_cs),
        .rd_word  (ee_word)
    );

    net_irq_agg #(.NUM_SLOTS(NUM_SLOTS)) i_net_irq_agg (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (net_irq_set),
        .clr_i (net_irq_clr),
        .irq_o (net_irq)
    );

    // status word for the selected slot and function
    logic        present, powered, ee_bit, is_sup;
    logic [31:0] status_word;

    assign present = |(sel_onehot & slot_present);
    assign powered = |(sel_onehot & pwr_flags);
    assign ee_bit  = slot_cs_raw && |(sel_onehot & slot_ee_dout);
    assign is_sup  = (sel_slot == SLOT_W'(SUP_SLOT));

    always_comb begin
        status_word = '0;
        case (sel_func)
            FN_PRESENCE: status_word = !present ? 32'h1 :
                                       ((powered || is_sup) ? 32'h2 : 32'h0);
            FN_ABSENT:   status_word = present ? 32'h0 : 32'h1;
            FN_POWER:    status_word = 32'h8;
            FN_EEPROM:   status_word = {31'd0, ee_bit};
            default:     status_word = '0;
        endcase
    end

    logic [31:0] rd_mux;
    always_comb begin
        case (bus_addr)
            ADDR_W'(OFS_SLOT_ID): rd_mux = SLOT_ID_WORD;
            ADDR_W'(OFS_ZERO_A),
            ADDR_W'(OFS_ZERO_B),
            ADDR_W'(OFS_ZERO_C),
            ADDR_W'(OFS_ZERO_D),
            ADDR_W'(OFS_ZERO_E):  rd_mux = 32'h0;
            ADDR_W'(OFS_CONST):   rd_mux = 32'h8000;
            ADDR_W'(OFS_EE_RD):   rd_mux = ee_word;
            ADDR_W'(OFS_STATUS):  rd_mux = status_word;
            default:              rd_mux = 32'hFFFF_FFFF;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (acc_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    assign bus_rvalid = (state_q == BUS_RESP);

    AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |=> !bus_rvalid); // R13
    AST_RD_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rvalid && bus_rd && !bus_wr) |=> bus_rvalid); // R13
    AST_RESP_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |=> ($stable(sel_slot) && $stable(sel_func))); // R13

endmodule

// File: tb/test_slot_mgmt_regs.sv
module test_slot_mgmt_regs;
    localparam int NS = 9;
    localparam int NB = 9;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic [NS-1:0] slot_present = 9'h105;
    logic [NS-1:0] slot_ee_dout = '0;
    logic          slot_ee_di, slot_ee_clk;
    logic [NS-1:0] slot_ee_cs;
    logic [NB-1:0] bp_ee_dout = '0;
    logic          bp_ee_di, bp_ee_clk;
    logic [NB-1:0] bp_ee_cs;
    logic [1:0]    sup_ee_dout = '0;
    logic [1:0]    sup_ee_di, sup_ee_clk, sup_ee_cs;
    logic [NS-1:0] net_irq_set = '0, net_irq_clr = '0;
    logic          net_irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    slot_mgmt_regs #(.NUM_SLOTS(NS), .SUP_SLOT(1), .NUM_BP_EE(NB), .ADDR_W(AW)) i_slot_mgmt_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .slot_present(slot_present), .slot_ee_dout(slot_ee_dout), .slot_ee_di(slot_ee_di),
        .slot_ee_clk(slot_ee_clk), .slot_ee_cs(slot_ee_cs), .bp_ee_dout(bp_ee_dout),
        .bp_ee_di(bp_ee_di), .bp_ee_clk(bp_ee_clk), .bp_ee_cs(bp_ee_cs),
        .sup_ee_dout(sup_ee_dout), .sup_ee_di(sup_ee_di), .sup_ee_clk(sup_ee_clk),
        .sup_ee_cs(sup_ee_cs), .net_irq_set(net_irq_set), .net_irq_clr(net_irq_clr),
        .net_irq(net_irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check("R13 rvalid", 32'(bus_rvalid), 32'h1);
        d = bus_rdata;
    endtask

    function automatic logic [31:0] sel(input int slot, input int fn);
        return (32'(slot) << 12) | (32'(fn) << 8);
    endfunction

    task automatic status_of(input string req, input int slot, input int fn, input logic [31:0] exp);
        logic [31:0] v;
        bus_write(8'h44, sel(slot, fn));
        bus_read(8'h4C, v);
        check(req, v, exp);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 irq", 32'(net_irq), 0);
        check("R1 bp cs", 32'(bp_ee_cs), 0);
        check("R1 slot cs", 32'(slot_ee_cs), 0);
        check("R1 sup cs", 32'(sup_ee_cs), 0);
        check("R1 rvalid", 32'(bus_rvalid), 0);
        bus_read(8'h4C, v);
        check("R1 status after reset", v, 32'h1);
    endtask

    task automatic t_fixed;
        logic [31:0] v;
        bus_read(8'h04, v); check("R8 slot id", v, 32'h180);
        bus_read(8'h0C, v); check("R12 zero 0C", v, 0);
        bus_read(8'h74, v); check("R12 zero 74", v, 0);
        bus_read(8'h18, v); check("R12 const 18", v, 32'h8000);
        bus_read(8'h30, v); check("R12 unmapped", v, 32'hFFFF_FFFF);
        bus_read(8'h44, v); check("R12 selector read", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_presence;
        status_of("R4 sup slot", 1, 0, 32'h2);
        status_of("R4 present unpowered", 3, 0, 32'h0);
        status_of("R4 absent", 2, 0, 32'h1);
        status_of("R5 present", 9, 1, 32'h0);
        status_of("R5 absent", 2, 1, 32'h1);
        status_of("R6 power fn", 3, 2, 32'h8);
        status_of("R2 powered sticky", 3, 0, 32'h2);
        status_of("R2 slot9 unpowered", 9, 0, 32'h0);
        status_of("R6 unknown fn", 3, 7, 32'h0);
    endtask

    task automatic t_invalid;
        bus_write(8'h44, sel(10, 2));
        bus_write(8'h44, sel(0, 2));
        status_of("R3 slot9 untouched", 9, 0, 32'h0);
        status_of("R3 slot 10 fn0", 10, 0, 32'h1);
        status_of("R3 slot 15 fn1", 15, 1, 32'h1);
        status_of("R3 slot 0 fn0", 0, 0, 32'h1);
    endtask

    task automatic t_slot_ee;
        logic [31:0] v;
        slot_ee_dout = 9'h100;
        bus_write(8'h44, sel(9, 5));
        bus_write(8'h48, 32'hB);
        check("R7 cs one-hot", 32'(slot_ee_cs), 32'h100);
        check("R7 di", 32'(slot_ee_di), 1);
        check("R7 clk", 32'(slot_ee_clk), 1);
        bus_read(8'h4C, v); check("R7 dout active", v, 32'h1);
        bus_write(8'h48, 32'h3);
        bus_read(8'h4C, v); check("R7 dout inactive cs", v, 32'h0);
        bus_write(8'h48, 32'h8);
        status_of("R3 fn5 invalid slot", 10, 5, 32'h0);
        check("R3 no cs for invalid slot", 32'(slot_ee_cs), 0);
        bus_write(8'h48, 32'h0);
    endtask

    task automatic t_bp_ee;
        logic [31:0] v;
        bus_write(8'h20, 32'h2B);
        check("R10 bp cs", 32'(bp_ee_cs), 32'h005);
        check("R10 bp di/clk", {30'd0, bp_ee_clk, bp_ee_di}, 32'h3);
        bp_ee_dout = 9'h002;
        bus_read(8'h3C, v); check("R9 inactive bp", v, 32'h0);
        bp_ee_dout = 9'h004;
        bus_read(8'h3C, v); check("R9 active bp", v, 32'h1);
        bus_write(8'h24, 32'h00000708);
        check("R10 sup cs", 32'(sup_ee_cs), 32'h3);
        check("R10 sup di", 32'(sup_ee_di), 32'h2);
        check("R10 sup clk", 32'(sup_ee_clk), 32'h2);
        bus_write(8'h24, 32'h8);
        bp_ee_dout = 9'h0;
        sup_ee_dout = 2'b10;
        bus_read(8'h3C, v); check("R9 sup inactive", v, 32'h0);
        sup_ee_dout = 2'b01;
        bus_read(8'h3C, v); check("R9 sup force", v, 32'hFFFF);
        sup_ee_dout = 2'b00;
    endtask

    task automatic t_irq;
        @(negedge clk); net_irq_set = 9'h002;
        @(negedge clk); net_irq_set = '0;
        check("R11 irq set", 32'(net_irq), 1);
        net_irq_set = 9'h008;
        @(negedge clk); net_irq_set = '0; net_irq_clr = 9'h002;
        @(negedge clk); net_irq_clr = '0;
        check("R11 irq other pending", 32'(net_irq), 1);
        net_irq_set = 9'h008; net_irq_clr = 9'h008;
        @(negedge clk); net_irq_set = '0; net_irq_clr = 9'h008;
        check("R11 set wins", 32'(net_irq), 1);
        @(negedge clk); net_irq_clr = '0;
        check("R11 irq cleared", 32'(net_irq), 0);
    endtask

    task automatic t_resp_ignore;
        logic [31:0] v;
        bus_write(8'h44, sel(9, 0));
        @(negedge clk);
        bus_addr = 8'h4C; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check("R13 rvalid", 32'(bus_rvalid), 1);
        check("R13 data", bus_rdata, 32'h0);
        bus_addr = 8'h44; bus_wdata = sel(9, 2); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R13 rvalid one cycle", 32'(bus_rvalid), 0);
        bus_read(8'h4C, v);
        check("R13 write in resp ignored", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fixed();
        t_presence();
        t_invalid();
        t_slot_ee();
        t_bp_ee();
        t_irq();
        t_resp_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule